// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches eight general-purpose input pins, grouped as two 4-bit ports, and raises one shared interrupt request when a pin makes a transition of the selected polarity. A pin takes part in detection only while its direction bit marks it as an input. A pin driven as an output cannot raise the request, and it cannot hold off re-arming either.

Each pin passes through a synchroniser before any edge is detected. After a trigger the detector locks. Further edges of the same kind are ignored until every participating pin has returned to the idle level. For falling-edge mode the idle level is high, and for rising-edge mode it is low.

The request flag is sticky and is set whether or not the enable is asserted. It clears on a strobe. The wake output is the flag gated by the enable. When the polarity selection changes, the detector disarms, and it re-arms only once all participating pins sit at the idle level of the new polarity.

Top module: `portchg_irq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_flag` and `wake` are 0.
- R2: With `edge_rise` = 0, a high-to-low change on a participating pin sets `irq_flag`. The flag is seen at the third rising clock edge after the pin changes and not at the second.
- R3: With `edge_rise` = 1, a low-to-high change on a participating pin sets `irq_flag`, with the same three-edge latency.
- R4: A pin whose `pin_dir` bit is 1 (output) never sets the flag, whatever its level does.
- R5: After a trigger, further active edges on any pin are ignored while at least one participating pin is still away from the idle level (idle is high for falling mode and low for rising mode).
- R6: Once all participating pins have been at the idle level for at least one cycle, the next active edge sets the flag again.
- R7: A pin configured as an output and held at the active level does not prevent re-arming.
- R8: `irq_flag` stays set until `flag_clr` is 1 at a rising edge, and it clears at that edge. If a trigger and a clear arrive on the same edge, the flag stays set.
- R9: `irq_flag` is set whether or not `irq_en` is asserted. `wake` equals `irq_flag` AND `irq_en` with no added delay.
- R10: A change of `edge_rise` disarms detection. Edges of the new polarity are ignored until all participating pins have been at the new idle level.
- R11: Pins 3..0 form the first port and pins 7..4 the second. A pin of either port can raise the shared flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Pin levels; bits 3..0 first port, 7..4 second port |
| pin_dir | input | 8 | Direction per pin, 1 = output (masked), 0 = input |
| edge_rise | input | 1 | 0 = detect falling edges, 1 = detect rising edges |
| irq_en | input | 1 | Interrupt enable gating `wake` |
| flag_clr | input | 1 | Clear strobe for the request flag |
| irq_flag | output | 1 | Sticky interrupt request flag |
| wake | output | 1 | Request flag ANDed with enable |

## Verification
A pin change driven between clock edges reaches `irq_flag` at the third rising edge: two edges go to the synchroniser and one to the flag register. The bench therefore samples at the falling edge after that third rising edge. For latency checks it also confirms that the flag is still low one edge earlier. A clear strobe acts at the next rising edge. `wake` follows `irq_en` combinationally and is sampled a nanosecond after the enable is changed. Re-arming needs the synchronised idle state to be registered, so the bench waits four cycles after restoring the idle level before it drives the next edge.

// File: rtl/portchg_pkg.sv
// Shared constants for the port change interrupt detector.
// Assumes two ports of four pins each unless overridden at the top.
package portchg_pkg;
    parameter int PORT_W_DEF    = 4;
    parameter int NUM_PORTS_DEF = 2;
    parameter int SYNC_DEF      = 2;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } pol_e;
endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherency is implied.
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // capture raw pin levels
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_async;
                end
            end else begin : g_rest
                // shift through remaining stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= '0;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/edge_arm.sv
// Edge detector with lock-out: fires once on an active edge of any
// participating pin, then waits until all participating pins sit at the
// idle level before arming again. Assumes inputs are already synchronised.
module edge_arm
    import portchg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dir_out,
    input  pol_e         pol,
    output logic         trig
);
    logic [W-1:0] prev_q;
    logic         armed_q;
    pol_e         pol_q;
    logic [W-1:0] idle_vec;
    logic [W-1:0] part;
    logic         edge_hit;
    logic         all_idle;
    logic         pol_chg;

    // classify current pin state against the selected polarity
    always_comb begin
        idle_vec = (pol == POL_RISE) ? '0 : '1;
        part     = ~dir_out;
        edge_hit = |(part & (prev_q ^ cur) & (cur ^ idle_vec));
        all_idle = ((cur ^ idle_vec) & part) == '0;
        pol_chg  = (pol != pol_q);
        trig     = armed_q && edge_hit && !pol_chg;
    end

    // history, polarity memory and arming state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
            pol_q   <= POL_FALL;
        end else begin
            prev_q <= cur;
            pol_q  <= pol;
            if (pol_chg || trig) armed_q <= 1'b0;
            else if (all_idle)   armed_q <= 1'b1;
        end
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R5
    AST_ALL_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&dir_out) |-> !trig); // R4
endmodule

// File: rtl/irq_latch.sv
// Sticky request flag: set on trigger, cleared by strobe, set has priority.
// Assumes trig and clr are single-clock synchronous pulses or levels.
module irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // hold the request until software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q); // R8
endmodule

// File: rtl/portchg_irq.sv
// Port change interrupt detector top. Synchronises all port pins, detects
// the selected edge on input-configured pins with re-arm lock-out, and
// keeps a sticky request flag plus an enable-gated wake output.
// Assumes direction and polarity controls are synchronous to clk.
module portchg_irq
    import portchg_pkg::*;
#(
    parameter int PORT_W    = PORT_W_DEF,
    parameter int NUM_PORTS = NUM_PORTS_DEF,
    parameter int SYNC_N    = SYNC_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORT_W*NUM_PORTS-1:0] pin_in,
    input  logic [PORT_W*NUM_PORTS-1:0] pin_dir,
    input  logic                        edge_rise,
    input  logic                        irq_en,
    input  logic                        flag_clr,
    output logic                        irq_flag,
    output logic                        wake
);
    localparam int PINS = PORT_W * NUM_PORTS;

    logic [PINS-1:0] pin_s;
    logic            trig;
    pol_e            pol;

    assign pol = pol_e'(edge_rise);

    pin_sync #(.W(PINS), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_s)
    );

    edge_arm #(.W(PINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (pin_s),
        .dir_out (pin_dir),
        .pol     (pol),
        .trig    (trig)
    );

    irq_latch u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (trig),
        .clr_i  (flag_clr),
        .flag_q (irq_flag)
    );

    assign wake = irq_flag & irq_en;

    AST_SET_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> irq_flag); // R2
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !trig) |=> !irq_flag); // R8
endmodule

// File: tb/sim_portchg_irq.sv
module sim_portchg_irq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pin_in;
    logic [7:0] pin_dir;
    logic       edge_rise;
    logic       irq_en;
    logic       flag_clr;
    logic       irq_flag;
    logic       wake;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    portchg_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .edge_rise(edge_rise), .irq_en(irq_en), .flag_clr(flag_clr),
        .irq_flag(irq_flag), .wake(wake)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic rise, input logic [7:0] lvl);
        rst_n = 1'b0; pin_in = lvl; pin_dir = 8'h00; edge_rise = rise;
        irq_en = 1'b0; flag_clr = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(5);
    endtask

    task automatic clear_pulse();
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pin_in = 8'h00; pin_dir = 8'h00; edge_rise = 1'b0;
        irq_en = 1'b1; flag_clr = 1'b0;
        step(3);
        check("R1 flag in reset", irq_flag, 1'b0);
        check("R1 wake in reset", wake, 1'b0);
        rst_n = 1'b1; step(1);
        check("R1 flag after reset", irq_flag, 1'b0);
    endtask

    task automatic t_fall_lockout();
        do_reset(1'b0, 8'hFF);
        pin_in[2] = 1'b0; step(2);
        check("R2 not yet at edge 2", irq_flag, 1'b0);
        step(1);
        check("R2 falling sets flag", irq_flag, 1'b1);
        clear_pulse();
        check("R8 clear strobe", irq_flag, 1'b0);
        pin_in[6] = 1'b0; step(4);
        check("R5 second fall ignored", irq_flag, 1'b0);
        pin_in[2] = 1'b1; step(4);
        pin_in[2] = 1'b0; step(4);
        check("R5 partial idle no rearm", irq_flag, 1'b0);
        pin_in = 8'hFF; step(4);
        pin_in[7] = 1'b0; step(3);
        check("R6 rearmed after all high", irq_flag, 1'b1);
        step(10);
        check("R8 flag sticky", irq_flag, 1'b1);
    endtask

    task automatic t_mask();
        do_reset(1'b0, 8'hFF);
        pin_dir = 8'h0F;
        pin_in[1] = 1'b0; step(4);
        check("R4 output pin ignored", irq_flag, 1'b0);
        pin_in[5] = 1'b0; step(3);
        check("R11 second port pin fires", irq_flag, 1'b1);
        clear_pulse();
        pin_in[5] = 1'b1; step(4);
        pin_in[4] = 1'b0; step(3);
        check("R7 masked low pin no block", irq_flag, 1'b1);
    endtask

    task automatic t_rise();
        do_reset(1'b1, 8'h00);
        pin_in[0] = 1'b1; step(2);
        check("R3 not yet at edge 2", irq_flag, 1'b0);
        step(1);
        check("R3 rising sets flag", irq_flag, 1'b1);
        clear_pulse();
        pin_in[3] = 1'b1; step(4);
        check("R5 rise lockout", irq_flag, 1'b0);
        pin_in = 8'h00; step(4);
        pin_in[3] = 1'b1; step(3);
        check("R6 rise rearm", irq_flag, 1'b1);
    endtask

    task automatic t_enable();
        do_reset(1'b0, 8'hFF);
        pin_in[3] = 1'b0; step(3);
        check("R9 flag without enable", irq_flag, 1'b1);
        check("R9 wake gated off", wake, 1'b0);
        irq_en = 1'b1; #1;
        check("R9 wake follows enable", wake, 1'b1);
        irq_en = 1'b0; #1;
        check("R9 wake drops with enable", wake, 1'b0);
    endtask

    task automatic t_clr_priority();
        do_reset(1'b0, 8'hFF);
        pin_in[0] = 1'b0; step(2);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        check("R8 set wins over clear", irq_flag, 1'b1);
        clear_pulse();
        check("R8 clear afterwards", irq_flag, 1'b0);
    endtask

    task automatic t_polarity();
        do_reset(1'b0, 8'hFF);
        edge_rise = 1'b1; step(2);
        pin_in[0] = 1'b0; step(4);
        pin_in[0] = 1'b1; step(4);
        check("R10 rise ignored until low idle", irq_flag, 1'b0);
        pin_in = 8'h00; step(4);
        pin_in[5] = 1'b1; step(3);
        check("R10 rearmed in new polarity", irq_flag, 1'b1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fall_lockout();
        t_mask();
        t_rise();
        t_enable();
        t_clr_priority();
        t_polarity();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule